// File: doc/BRIEF.md
# Address Translation Window Unit

This block holds a set of programmable address translation windows for a PCIe root port, organised as an inbound bank and an outbound bank with the same number of windows each. Software never addresses a window directly: it first writes a selector register naming a bank and a window index, and then programs that window's base, limit, target and two control words through a single shared group of register offsets. Register writes land in a staging copy; the window's live decode is refreshed only when its second control word is written, so a window can be reprogrammed field by field without ever decoding a half-written range.

On the request side, a request address and a bank choice enter together with a valid strobe. The block searches the chosen bank for an enabled window whose range covers the address. A memory window yields a translated address; a configuration window yields a bus number, a device/function number and a register offset. A request that no window covers is flagged as a miss and its address is passed through unchanged. A few fixed port-logic registers in the same register space return constant values so that driver polling loops terminate.

Top module: `xlat_window_unit`

## Requirements
- R1: The selector register at offset 0x900 reads back the last value written; bit 31 picks the inbound bank (1) or the outbound bank (0) and bits [3:0] pick the window. When bits [3:0] name a window at or above NUM_WIN, writes to the window offsets are dropped and reads of them return 0.
- R2: For the selected window, offsets 0x904 (control 1), 0x908 (control 2), 0x90C/0x910 (base low/high), 0x914 (32-bit limit) and 0x918/0x91C (target low/high) read back the staged values; a write to one half of base or target leaves the other half unchanged.
- R3: Writes to control 1, base, limit and target do not change translation until control 2 is written; that write makes the staged values live, takes the enable from bit 31 of the written value and the type from bits [4:0] of control 1.
- R4: A live enabled memory window (type 0) covers addresses A with base <= A <= limit (limit zero-extended to 64 bits) and translates A to target + (A - base).
- R5: A live enabled window of any non-zero type is a configuration window: a covered request sets res_cfg, gives bus = target[31:24], devfn = target[23:16], offset = (A - base) modulo 4096, and leaves res_addr equal to A.
- R6: A request covered by no enabled window sets res_miss, clears res_cfg, returns res_addr equal to the request address, and gives zero bus, devfn and offset (which are also zero on any memory hit).
- R7: When several enabled windows of the chosen bank cover the address, the lowest-numbered window decides the result.
- R8: After reset every window stages base 0, target 0, limit 0xFFFFFFFF, control 1 = 0; inbound window 0 stages control 2 = 0x80000000 and is live, so inbound addresses below 2^32 pass through untranslated; every other window is disabled, and the selector reads 0.
- R9: Offset 0x710 always reads 0xDEADBEEF, 0x80C reads 0x00020000 and 0x72C reads 0x00000010; writes to these three offsets have no effect.
- R10: res_valid is high exactly in the cycle after req_valid was sampled high, and the result fields belong to that request.
- R11: req_inbound selects which bank is searched: 1 for the inbound bank, 0 for the outbound bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register offset for writes and reads |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| req_valid | input | 1 | Request strobe |
| req_inbound | input | 1 | Bank choice for the request: 1 inbound, 0 outbound |
| req_addr | input | 64 | Request address |
| res_valid | output | 1 | Result strobe, one cycle after req_valid |
| res_miss | output | 1 | No enabled window covered the request |
| res_cfg | output | 1 | The request hit a configuration window |
| res_addr | output | 64 | Translated address, or the request address |
| res_bus | output | 8 | Bus number of a configuration hit |
| res_devfn | output | 8 | Device/function number of a configuration hit |
| res_off | output | 12 | Register offset of a configuration hit |

## Verification
Register reads are combinational, so a read check sets the offset on the falling edge and samples cfg_rdata shortly after, with no clock edge in between; a register write takes effect at the rising edge following its falling-edge setup, and a control 2 write changes translation for any request issued from the next falling edge on. A request presented on a falling edge is captured by the next rising edge, so every result field is compared on the falling edge one cycle later, and a further falling edge confirms that res_valid has dropped. A bench model of the staged and live window state, updated with each write in the same order as the hardware, supplies every expected value for both directed corner cases and randomly programmed windows.

// File: rtl/xwu_pkg.sv
// Shared types and register offsets for the address translation window unit.
// Assumes 32-bit register accesses and 64-bit request addresses.
package xwu_pkg;

    localparam int CFG_OFF_W = 12;

    localparam logic [11:0] OFS_SELECTOR  = 12'h900;
    localparam logic [11:0] OFS_CTL1      = 12'h904;
    localparam logic [11:0] OFS_CTL2      = 12'h908;
    localparam logic [11:0] OFS_BASE_LO   = 12'h90C;
    localparam logic [11:0] OFS_BASE_HI   = 12'h910;
    localparam logic [11:0] OFS_LIMIT     = 12'h914;
    localparam logic [11:0] OFS_TGT_LO    = 12'h918;
    localparam logic [11:0] OFS_TGT_HI    = 12'h91C;
    localparam logic [11:0] OFS_LINK_CTL  = 12'h710;
    localparam logic [11:0] OFS_PHY_STAT  = 12'h72C;
    localparam logic [11:0] OFS_SPEED_CTL = 12'h80C;

    typedef enum logic [2:0] {
        FLD_NONE, FLD_CTL1, FLD_CTL2, FLD_BASE_LO,
        FLD_BASE_HI, FLD_LIMIT, FLD_TGT_LO, FLD_TGT_HI
    } fld_e;

    // Staged, software-visible copy of one window.
    typedef struct packed {
        logic [31:0] ctl1;
        logic [31:0] ctl2;
        logic [63:0] base;
        logic [31:0] limit;
        logic [63:0] target;
    } win_regs_t;

    // Live decode of one window, refreshed on a control 2 write.
    typedef struct packed {
        logic        en;
        logic        is_cfg;
        logic [63:0] base;
        logic [63:0] last;
        logic [63:0] target;
    } win_act_t;

    function automatic fld_e decode_field(input logic [11:0] ofs);
        case (ofs)
            OFS_CTL1:    return FLD_CTL1;
            OFS_CTL2:    return FLD_CTL2;
            OFS_BASE_LO: return FLD_BASE_LO;
            OFS_BASE_HI: return FLD_BASE_HI;
            OFS_LIMIT:   return FLD_LIMIT;
            OFS_TGT_LO:  return FLD_TGT_LO;
            OFS_TGT_HI:  return FLD_TGT_HI;
            default:     return FLD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/xwu_window.sv
// One translation window: staged register copy plus live decode.
// Assumes wr_en is already qualified with the window selection.
// The live decode is reloaded only when control 2 is written.
module xwu_window
    import xwu_pkg::*;
#(
    parameter bit RESET_ON = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  fld_e        fld,
    input  logic [31:0] wdata,
    output win_regs_t   regs,
    output win_act_t    act
);

    localparam logic [31:0] CTL2_RST = RESET_ON ? 32'h8000_0000 : 32'h0;

    // Staged register writes and commit of the live decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs.ctl1   <= '0;
            regs.ctl2   <= CTL2_RST;
            regs.base   <= '0;
            regs.limit  <= 32'hFFFF_FFFF;
            regs.target <= '0;
            act.en      <= RESET_ON;
            act.is_cfg  <= 1'b0;
            act.base    <= '0;
            act.last    <= 64'h0000_0000_FFFF_FFFF;
            act.target  <= '0;
        end else if (wr_en) begin
            case (fld)
                FLD_CTL1:    regs.ctl1          <= wdata;
                FLD_BASE_LO: regs.base[31:0]    <= wdata;
                FLD_BASE_HI: regs.base[63:32]   <= wdata;
                FLD_LIMIT:   regs.limit         <= wdata;
                FLD_TGT_LO:  regs.target[31:0]  <= wdata;
                FLD_TGT_HI:  regs.target[63:32] <= wdata;
                FLD_CTL2: begin
                    regs.ctl2  <= wdata;
                    act.en     <= wdata[31];
                    act.is_cfg <= (regs.ctl1[4:0] != 5'd0);
                    act.base   <= regs.base;
                    act.last   <= {32'h0, regs.limit};
                    act.target <= regs.target;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/xwu_lookup.sv
// Priority search of one bank of live windows for a request address.
// Combinational; lowest-numbered covering window decides.
module xwu_lookup
    import xwu_pkg::*;
#(
    parameter int NW = 4
) (
    input  win_act_t               win [NW],
    input  logic [63:0]            addr,
    output logic                   hit,
    output logic                   is_cfg,
    output logic [63:0]            xaddr,
    output logic [7:0]             bus,
    output logic [7:0]             devfn,
    output logic [CFG_OFF_W-1:0]   off
);

    localparam int IW = (NW > 1) ? $clog2(NW) : 1;

    logic [NW-1:0] match;
    logic [IW-1:0] pick;
    logic [63:0]   delta;

    generate
        for (genvar g = 0; g < NW; g++) begin : g_match
            assign match[g] = win[g].en && (addr >= win[g].base) && (addr <= win[g].last);
        end
    endgenerate

    // Choose the lowest matching index.
    always_comb begin
        pick = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            if (match[i]) pick = IW'(i);
        end
    end

    // Form the result of the chosen window.
    always_comb begin
        hit    = |match;
        is_cfg = hit && win[pick].is_cfg;
        delta  = addr - win[pick].base;
        xaddr  = (hit && !win[pick].is_cfg) ? (win[pick].target + delta) : addr;
        bus    = is_cfg ? win[pick].target[31:24] : 8'h00;
        devfn  = is_cfg ? win[pick].target[23:16] : 8'h00;
        off    = is_cfg ? delta[CFG_OFF_W-1:0] : '0;
    end

endmodule

// File: rtl/xlat_window_unit.sv
// Address translation window unit: selector-indexed register access to
// inbound and outbound window banks, and a registered request lookup.
// Assumes NUM_WIN <= 16; one register access per cycle, reads combinational.
module xlat_window_unit
    import xwu_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [11:0]          cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic                 req_valid,
    input  logic                 req_inbound,
    input  logic [63:0]          req_addr,
    output logic                 res_valid,
    output logic                 res_miss,
    output logic                 res_cfg,
    output logic [63:0]          res_addr,
    output logic [7:0]           res_bus,
    output logic [7:0]           res_devfn,
    output logic [CFG_OFF_W-1:0] res_off
);

    localparam int          IW  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam logic [4:0]  NW5 = 5'(NUM_WIN);

    logic [31:0] selector;
    fld_e        fld;
    logic        sel_ok;
    logic [IW-1:0] sel_idx;
    win_regs_t   regs_arr [2][NUM_WIN];
    win_act_t    act_arr  [2][NUM_WIN];
    win_act_t    act_pick [NUM_WIN];
    win_regs_t   cur;

    logic                 lk_hit, lk_cfg;
    logic [63:0]          lk_addr;
    logic [7:0]           lk_bus, lk_devfn;
    logic [CFG_OFF_W-1:0] lk_off;

    assign fld     = decode_field(cfg_addr);
    assign sel_ok  = ({1'b0, selector[3:0]} < NW5);
    assign sel_idx = selector[IW-1:0];

    // Selector register holding bank and window index.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  selector <= '0;
        else if (cfg_wr && cfg_addr == OFS_SELECTOR) selector <= cfg_wdata;
    end

    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
                logic hit_me;
                assign hit_me = cfg_wr && (fld != FLD_NONE) &&
                                (selector[31] == 1'(b)) && (selector[3:0] == 4'(w));
                xwu_window #(.RESET_ON((b == 1) && (w == 0))) u_win (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .wr_en (hit_me),
                    .fld   (fld),
                    .wdata (cfg_wdata),
                    .regs  (regs_arr[b][w]),
                    .act   (act_arr[b][w])
                );
            end
        end
    endgenerate

    // Register read mux.
    always_comb begin
        cur       = regs_arr[selector[31]][sel_idx];
        cfg_rdata = '0;
        case (cfg_addr)
            OFS_LINK_CTL:  cfg_rdata = 32'hDEAD_BEEF;
            OFS_PHY_STAT:  cfg_rdata = 32'h0000_0010;
            OFS_SPEED_CTL: cfg_rdata = 32'h0002_0000;
            OFS_SELECTOR:  cfg_rdata = selector;
            default: begin
                if (sel_ok) begin
                    case (fld)
                        FLD_CTL1:    cfg_rdata = cur.ctl1;
                        FLD_CTL2:    cfg_rdata = cur.ctl2;
                        FLD_BASE_LO: cfg_rdata = cur.base[31:0];
                        FLD_BASE_HI: cfg_rdata = cur.base[63:32];
                        FLD_LIMIT:   cfg_rdata = cur.limit;
                        FLD_TGT_LO:  cfg_rdata = cur.target[31:0];
                        FLD_TGT_HI:  cfg_rdata = cur.target[63:32];
                        default:     cfg_rdata = '0;
                    endcase
                end
            end
        endcase
    end

    // Bank choice for the lookup.
    always_comb begin
        for (int i = 0; i < NUM_WIN; i++) begin
            act_pick[i] = req_inbound ? act_arr[1][i] : act_arr[0][i];
        end
    end

    xwu_lookup #(.NW(NUM_WIN)) u_lookup (
        .win    (act_pick),
        .addr   (req_addr),
        .hit    (lk_hit),
        .is_cfg (lk_cfg),
        .xaddr  (lk_addr),
        .bus    (lk_bus),
        .devfn  (lk_devfn),
        .off    (lk_off)
    );

    // Result register, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_miss  <= 1'b0;
            res_cfg   <= 1'b0;
            res_addr  <= '0;
            res_bus   <= '0;
            res_devfn <= '0;
            res_off   <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_miss  <= !lk_hit;
                res_cfg   <= lk_cfg;
                res_addr  <= lk_addr;
                res_bus   <= lk_bus;
                res_devfn <= lk_devfn;
                res_off   <= lk_off;
            end
        end
    end

endmodule

// File: rtl/xlat_window_unit_chk.sv
// Checker for the translation window unit, bound to every instance.
// Observes ports only.
module xlat_window_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] cfg_addr,
    input logic [31:0] cfg_rdata,
    input logic        req_valid,
    input logic [63:0] req_addr,
    input logic        res_valid,
    input logic        res_miss,
    input logic        res_cfg,
    input logic [63:0] res_addr
);

    // R10
    res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    // R10
    res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    // R6
    miss_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!res_miss || res_addr == $past(req_addr)));

    // R5
    cfg_not_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_cfg) |-> !res_miss);

    // R9
    link_ctl_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 12'h710) |-> (cfg_rdata == 32'hDEAD_BEEF));

    // R9
    speed_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 12'h80C) |-> cfg_rdata[17]);

    // R9
    link_up_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 12'h72C) |-> cfg_rdata[4]);

endmodule

bind xlat_window_unit xlat_window_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .res_valid (res_valid),
    .res_miss  (res_miss),
    .res_cfg   (res_cfg),
    .res_addr  (res_addr)
);

// File: tb/xlat_window_unit_test.sv
module xlat_window_unit_test;

    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_inbound = 1'b0;
    logic [63:0] req_addr = '0;
    logic        res_valid, res_miss, res_cfg;
    logic [63:0] res_addr;
    logic [7:0]  res_bus, res_devfn;
    logic [11:0] res_off;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xlat_window_unit #(.NUM_WIN(NW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_inbound(req_inbound), .req_addr(req_addr), .res_valid(res_valid),
        .res_miss(res_miss), .res_cfg(res_cfg), .res_addr(res_addr),
        .res_bus(res_bus), .res_devfn(res_devfn), .res_off(res_off)
    );

    // Bench model of staged and live window state.
    logic [31:0] m_sel;
    logic [31:0] s_ctl1 [2][NW];
    logic [31:0] s_ctl2 [2][NW];
    logic [31:0] s_lim  [2][NW];
    logic [63:0] s_base [2][NW];
    logic [63:0] s_tgt  [2][NW];
    logic        a_en   [2][NW];
    logic        a_cfg  [2][NW];
    logic [63:0] a_base [2][NW];
    logic [63:0] a_last [2][NW];
    logic [63:0] a_tgt  [2][NW];

    task automatic m_reset();
        m_sel = '0;
        for (int b = 0; b < 2; b++) begin
            for (int w = 0; w < NW; w++) begin
                s_ctl1[b][w] = '0;
                s_ctl2[b][w] = (b == 1 && w == 0) ? 32'h8000_0000 : 32'h0;
                s_lim[b][w]  = 32'hFFFF_FFFF;
                s_base[b][w] = '0;
                s_tgt[b][w]  = '0;
                a_en[b][w]   = (b == 1 && w == 0);
                a_cfg[b][w]  = 1'b0;
                a_base[b][w] = '0;
                a_last[b][w] = 64'hFFFF_FFFF;
                a_tgt[b][w]  = '0;
            end
        end
    endtask

    task automatic m_write(input logic [11:0] a, input logic [31:0] d);
        int b, w;
        b = int'(m_sel[31]);
        w = int'(m_sel[3:0]);
        if (a == 12'h900) m_sel = d;
        else if (w < NW) begin
            case (a)
                12'h904: s_ctl1[b][w] = d;
                12'h90C: s_base[b][w][31:0] = d;
                12'h910: s_base[b][w][63:32] = d;
                12'h914: s_lim[b][w] = d;
                12'h918: s_tgt[b][w][31:0] = d;
                12'h91C: s_tgt[b][w][63:32] = d;
                12'h908: begin
                    s_ctl2[b][w] = d;
                    a_en[b][w]   = d[31];
                    a_cfg[b][w]  = (s_ctl1[b][w][4:0] != 5'd0);
                    a_base[b][w] = s_base[b][w];
                    a_last[b][w] = {32'h0, s_lim[b][w]};
                    a_tgt[b][w]  = s_tgt[b][w];
                end
                default: ;
            endcase
        end
    endtask

    function automatic logic [31:0] m_read(input logic [11:0] a);
        int b, w;
        b = int'(m_sel[31]);
        w = int'(m_sel[3:0]);
        case (a)
            12'h710: return 32'hDEAD_BEEF;
            12'h72C: return 32'h0000_0010;
            12'h80C: return 32'h0002_0000;
            12'h900: return m_sel;
            default: ;
        endcase
        if (w >= NW) return 32'h0;
        case (a)
            12'h904: return s_ctl1[b][w];
            12'h908: return s_ctl2[b][w];
            12'h90C: return s_base[b][w][31:0];
            12'h910: return s_base[b][w][63:32];
            12'h914: return s_lim[b][w];
            12'h918: return s_tgt[b][w][31:0];
            12'h91C: return s_tgt[b][w][63:32];
            default: return 32'h0;
        endcase
    endfunction

    // Expected {miss, cfg, addr, bus, devfn, off}.
    function automatic logic [93:0] m_lookup(input logic inb, input logic [63:0] a);
        int b;
        logic [63:0] dl;
        b = int'(inb);
        for (int w = 0; w < NW; w++) begin
            if (a_en[b][w] && a >= a_base[b][w] && a <= a_last[b][w]) begin
                dl = a - a_base[b][w];
                if (a_cfg[b][w])
                    return {1'b0, 1'b1, a, a_tgt[b][w][31:24], a_tgt[b][w][23:16], dl[11:0]};
                return {1'b0, 1'b0, a_tgt[b][w] + dl, 8'h0, 8'h0, 12'h0};
            end
        end
        return {1'b1, 1'b0, a, 8'h0, 8'h0, 12'h0};
    endfunction

    task automatic note(input bit ok, input string tag, input logic [93:0] act, input logic [93:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        m_write(a, d);
    endtask

    task automatic rd_chk(input logic [11:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        cfg_addr = a;
        #1;
        e = m_read(a);
        note(cfg_rdata === e, tag, 94'(cfg_rdata), 94'(e));
    endtask

    task automatic req_chk(input logic inb, input logic [63:0] a, input string tag);
        logic [93:0] e, got;
        @(negedge clk);
        req_valid = 1'b1; req_inbound = inb; req_addr = a;
        e = m_lookup(inb, a);
        @(negedge clk);
        req_valid = 1'b0;
        got = {res_miss, res_cfg, res_addr, res_bus, res_devfn, res_off};
        note(res_valid === 1'b1, {tag, " R10 valid"}, 94'(res_valid), 94'(1));
        note(got === e, tag, got, e);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] bs, ln;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_1234);
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        note(res_valid === 1'b0, "R8 res_valid after reset", 94'(res_valid), 94'(0));
        rd_chk(12'h900, "R8 selector");
        rd_chk(12'h914, "R8 limit");
        rd_chk(12'h908, "R8 outbound ctl2");
        wr(12'h900, 32'h8000_0000);
        rd_chk(12'h908, "R8 inbound0 ctl2");
        rd_chk(12'h90C, "R8 base");
        req_chk(1'b1, 64'h1234_5678, "R8 inbound identity");
        req_chk(1'b1, 64'h1_0000_0000, "R8 inbound above limit");
        req_chk(1'b0, 64'h0000_1000, "R6 outbound miss");
        @(negedge clk);
        note(res_valid === 1'b0, "R10 valid drops", 94'(res_valid), 94'(0));

        // R9 fixed registers ignore writes
        wr(12'h710, 32'h0); rd_chk(12'h710, "R9 link ctl");
        wr(12'h72C, 32'h0); rd_chk(12'h72C, "R9 phy status");
        wr(12'h80C, 32'h0); rd_chk(12'h80C, "R9 speed ctl");

        // R1 out-of-range index
        wr(12'h900, 32'h0000_000A);
        wr(12'h90C, 32'h55);
        rd_chk(12'h90C, "R1 out of range read");
        rd_chk(12'h900, "R1 selector readback");
        wr(12'h900, 32'h0000_0002);
        rd_chk(12'h90C, "R1 window 2 untouched");

        // R2 halves
        wr(12'h90C, 32'h0000_1000);
        wr(12'h910, 32'h0000_0007);
        wr(12'h918, 32'hCAFE_0000);
        wr(12'h91C, 32'h0000_00AB);
        rd_chk(12'h90C, "R2 base lo");
        rd_chk(12'h910, "R2 base hi");
        wr(12'h918, 32'h1111_2222);
        rd_chk(12'h91C, "R2 target hi kept");
        rd_chk(12'h918, "R2 target lo");

        // R3/R4 memory window staging and bounds
        wr(12'h900, 32'h0);
        wr(12'h90C, 32'h2000);
        wr(12'h914, 32'h2FFF);
        wr(12'h91C, 32'hAB);
        req_chk(1'b0, 64'h2100, "R3 staged not live");
        wr(12'h908, 32'h8000_0000);
        req_chk(1'b0, 64'h2100, "R4 translate");
        req_chk(1'b0, 64'h2FFF, "R4 upper bound");
        req_chk(1'b0, 64'h3000, "R4 above limit");
        req_chk(1'b0, 64'h1FFF, "R4 below base");
        wr(12'h90C, 32'h5000);
        req_chk(1'b0, 64'h2100, "R3 base staged only");

        // R7 priority
        wr(12'h900, 32'h1);
        wr(12'h90C, 32'h2000);
        wr(12'h914, 32'h2FFF);
        wr(12'h918, 32'h7700_0000);
        wr(12'h908, 32'h8000_0000);
        req_chk(1'b0, 64'h2100, "R7 lowest wins");
        wr(12'h900, 32'h0);
        wr(12'h908, 32'h0);
        req_chk(1'b0, 64'h2100, "R7 next window");

        // R5 configuration window
        wr(12'h900, 32'h3);
        wr(12'h904, 32'h4);
        wr(12'h90C, 32'h4000_0000);
        wr(12'h914, 32'h4000_FFFF);
        wr(12'h918, 32'h0312_0000);
        wr(12'h908, 32'h8000_0000);
        req_chk(1'b0, 64'h4000_0ABC, "R5 cfg hit");
        req_chk(1'b0, 64'h4000_1ABC, "R5 cfg offset wrap");

        // R11 bank choice
        req_chk(1'b1, 64'h4000_0ABC, "R11 inbound same address");
        req_chk(1'b0, 64'h2100, "R11 outbound");

        // Random programming and requests
        for (int it = 0; it < 60; it++) begin
            wr(12'h900, {$urandom_range(1, 0) == 1 ? 1'b1 : 1'b0, 27'h0, 4'($urandom_range(5, 0))});
            bs = $urandom & 32'h00FF_FF00;
            ln = bs + ($urandom & 32'h0000_FFFF);
            wr(12'h904, ($urandom_range(3, 0) == 0) ? 32'h4 : 32'h0);
            wr(12'h90C, bs);
            wr(12'h914, ln);
            wr(12'h918, $urandom);
            wr(12'h91C, $urandom);
            rd_chk(12'h914, "R2 random limit");
            if ($urandom_range(4, 0) != 0) wr(12'h908, {$urandom_range(3, 0) != 0, 31'h0});
            for (int k = 0; k < 4; k++) begin
                req_chk($urandom_range(1, 0) == 1,
                        {32'h0, bs + ($urandom & 32'h0001_FFFF) - 32'h100},
                        "R4 R5 R6 R7 random");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule